// File: doc/BRIEF.md
# Masked Vector Ternary Logic Unit

This datapath block takes three 512-bit operands and combines them bit by bit. An 8-bit truth-table byte selects any Boolean function of three inputs. For each bit position, the three operand bits form a 3-bit index, and that index picks one bit of the truth-table byte. The vector is then divided into lanes: eight 64-bit lanes or sixteen 32-bit lanes, depending on an element-size select. A per-lane enable mask decides what each lane receives. An enabled lane takes the computed value. A disabled lane takes either zero or the matching lane of a merge-source vector, depending on a zero/merge select.

Each accepted operation is captured in a single output register. The result and its valid flag appear one clock after the input strobe. Decoding, register-file access and mask generation are done elsewhere. This block sees only the resolved operands, the truth-table byte and the mask.

Top module: `vec_tern_unit`

## Requirements
- R1: Each computed bit k equals `tt_imm[{opnd_a[k], opnd_b[k], opnd_c[k]}]`. Operand A supplies index bit 2 and operand C supplies index bit 0.
- R2: The truth-table byte 0x96 gives a^b^c, 0xE8 gives the majority of a, b and c, and 0xCA gives "a ? b : c".
- R3: The truth-table byte 0x00 gives all zeros, 0xFF gives all ones, 0x80 gives a&b&c and 0xFE gives a|b|c.
- R4: With `narrow_sel`=0, the vector has eight 64-bit lanes. `lane_en[N]` governs bits [64N+63:64N], and `lane_en[15:8]` has no effect.
- R5: With `narrow_sel`=1, the vector has sixteen 32-bit lanes. `lane_en[N]` governs bits [32N+31:32N].
- R6: With `zero_sel`=1, every lane whose enable bit is 0 outputs zero.
- R7: With `zero_sel`=0, every lane whose enable bit is 0 outputs the same lane of `merge_src`.
- R8: `out_valid` is high exactly one clock after a cycle with `in_valid` high. `out_data` is loaded on that same edge and holds its value while `in_valid` is low.
- R9: A synchronous active-high `rst` clears `out_valid` and `out_data` to zero on the next clock edge, overriding any input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| opnd_a | input | 512 | Operand A (truth-table index bit 2) |
| opnd_b | input | 512 | Operand B (truth-table index bit 1) |
| opnd_c | input | 512 | Operand C (truth-table index bit 0) |
| tt_imm | input | 8 | Truth-table byte |
| lane_en | input | 16 | Per-lane enable mask |
| zero_sel | input | 1 | 1: disabled lanes are zeroed; 0: disabled lanes are merged |
| narrow_sel | input | 1 | 1: 32-bit lanes; 0: 64-bit lanes |
| merge_src | input | 512 | Source for disabled lanes in merge mode |
| out_valid | output | 1 | Result valid |
| out_data | output | 512 | Registered result |

## Verification
Every result is due exactly one clock edge after the strobe, because the only register between input and output is the output stage. The bench applies inputs on a falling edge and lets one rising edge pass. It then samples `out_data` and `out_valid` a short delay after that edge, so each check reads the register that was just loaded. For hold and reset cases, the bench lets one more edge pass before it samples. It then compares against the value computed in the bench from the previous operation, or against zero.

// File: rtl/vtl_pkg.sv
package vtl_pkg;
  typedef enum logic {ELEM_WIDE = 1'b0, ELEM_NARROW = 1'b1} elem_mode_e;
  localparam int TT_W = 8;
endpackage

// File: rtl/vtl_bitfunc.sv
module vtl_bitfunc #(
  parameter int VEC_W = 512
) (
  input  logic [VEC_W-1:0]       a_i,
  input  logic [VEC_W-1:0]       b_i,
  input  logic [VEC_W-1:0]       c_i,
  input  logic [vtl_pkg::TT_W-1:0] tt_i,
  output logic [VEC_W-1:0]       y_o
);
  for (genvar k = 0; k < VEC_W; k++) begin : g_bit
    assign y_o[k] = tt_i[{a_i[k], b_i[k], c_i[k]}];
  end
endmodule

// File: rtl/vtl_lane_sel.sv
module vtl_lane_sel #(
  parameter int VEC_W    = 512,
  parameter int NARROW_W = 32,
  parameter int WIDE_W   = 64,
  localparam int MASK_W  = VEC_W / NARROW_W,
  localparam int RATIO   = WIDE_W / NARROW_W
) (
  input  logic [MASK_W-1:0] lane_en_i,
  input  vtl_pkg::elem_mode_e mode_i,
  output logic [VEC_W-1:0]  bit_en_o
);
  for (genvar j = 0; j < MASK_W; j++) begin : g_lane
    logic en;
    assign en = (mode_i == vtl_pkg::ELEM_NARROW) ? lane_en_i[j] : lane_en_i[j / RATIO];
    assign bit_en_o[j*NARROW_W +: NARROW_W] = {NARROW_W{en}};
  end
endmodule

// File: rtl/vec_tern_unit.sv
module vec_tern_unit #(
  parameter int VEC_W    = 512,
  parameter int NARROW_W = 32,
  parameter int WIDE_W   = 64,
  localparam int MASK_W  = VEC_W / NARROW_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [VEC_W-1:0]  opnd_a,
  input  logic [VEC_W-1:0]  opnd_b,
  input  logic [VEC_W-1:0]  opnd_c,
  input  logic [7:0]        tt_imm,
  input  logic [MASK_W-1:0] lane_en,
  input  logic              zero_sel,
  input  logic              narrow_sel,
  input  logic [VEC_W-1:0]  merge_src,
  output logic              out_valid,
  output logic [VEC_W-1:0]  out_data
);
  logic [VEC_W-1:0] func_y;
  logic [VEC_W-1:0] bit_en;
  logic [VEC_W-1:0] fill;
  logic [VEC_W-1:0] next_data;
  vtl_pkg::elem_mode_e mode;

  assign mode = narrow_sel ? vtl_pkg::ELEM_NARROW : vtl_pkg::ELEM_WIDE;

  vtl_bitfunc #(.VEC_W(VEC_W)) u_func (
    .a_i(opnd_a), .b_i(opnd_b), .c_i(opnd_c), .tt_i(tt_imm), .y_o(func_y)
  );

  vtl_lane_sel #(.VEC_W(VEC_W), .NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) u_sel (
    .lane_en_i(lane_en), .mode_i(mode), .bit_en_o(bit_en)
  );

  always_comb begin
    fill      = zero_sel ? '0 : merge_src;
    next_data = (func_y & bit_en) | (fill & ~bit_en);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= next_data;
    end
  end
endmodule

// File: rtl/vtl_chk.sv
module vtl_chk #(
  parameter int VEC_W  = 512,
  parameter int MASK_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [7:0]        tt_imm,
  input logic [MASK_W-1:0] lane_en,
  input logic              zero_sel,
  input logic              narrow_sel,
  input logic [VEC_W-1:0]  merge_src,
  input logic              out_valid,
  input logic [VEC_W-1:0]  out_data
);
  p_valid_follow_r8: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_valid_drop_r8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_data));
  p_zero_all_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && zero_sel && lane_en == '0) |=> out_data == '0);
  p_merge_all_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !zero_sel && lane_en == '0) |=> out_data == $past(merge_src));
  p_const_one_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && tt_imm == 8'hFF && !narrow_sel && lane_en[7:0] == 8'hFF) |=> (&out_data));
endmodule

bind vec_tern_unit vtl_chk #(.VEC_W(VEC_W), .MASK_W(MASK_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .tt_imm(tt_imm), .lane_en(lane_en),
  .zero_sel(zero_sel), .narrow_sel(narrow_sel), .merge_src(merge_src),
  .out_valid(out_valid), .out_data(out_data)
);

// File: tb/sim_vec_tern_unit.sv
module sim_vec_tern_unit;
  localparam int CLK_PERIOD = 10;
  localparam int W = 512;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [W-1:0] a = '0, b = '0, c = '0, src = '0;
  logic [7:0] imm = '0;
  logic [15:0] msk = '0;
  logic zs = 1'b0, nar = 1'b0;
  logic out_valid;
  logic [W-1:0] out_data;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_tern_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .opnd_a(a), .opnd_b(b), .opnd_c(c),
    .tt_imm(imm), .lane_en(msk), .zero_sel(zs), .narrow_sel(nar), .merge_src(src),
    .out_valid(out_valid), .out_data(out_data)
  );

  function automatic logic [W-1:0] rnd();
    logic [W-1:0] v;
    for (int i = 0; i < W/32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [W-1:0] model(logic [W-1:0] xa, logic [W-1:0] xb, logic [W-1:0] xc,
      logic [7:0] t, logic [15:0] m, logic z, logic n, logic [W-1:0] s);
    logic [W-1:0] r;
    for (int k = 0; k < W; k++) begin
      int lane = n ? k / 32 : k / 64;
      int idx  = xa[k] * 4 + xb[k] * 2 + xc[k];
      r[k] = m[lane] ? t[idx] : (z ? 1'b0 : s[k]);
    end
    return r;
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk1(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // drive at falling edge, capture at rising edge, sample just after it
  task automatic op(logic [W-1:0] xa, logic [W-1:0] xb, logic [W-1:0] xc, logic [7:0] t,
      logic [15:0] m, logic z, logic n, logic [W-1:0] s);
    @(negedge clk);
    a = xa; b = xb; c = xc; imm = t; msk = m; zs = z; nar = n; src = s; in_valid = 1'b1;
    @(posedge clk); #1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    chk1("R9 valid after reset", out_valid, 1'b0);
    chk("R9 data after reset", out_data, '0);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_index_order();
    // R1: one-hot truth tables select exactly one operand combination
    for (int i = 0; i < 8; i++) begin
      logic [W-1:0] xa = rnd(), xb = rnd(), xc = rnd();
      op(xa, xb, xc, 8'(1 << i), 16'hFFFF, 1'b1, 1'b0, '0);
      chk($sformatf("R1 onehot tt bit %0d", i), out_data,
          ({W{i[2]}} ~^ xa) & ({W{i[1]}} ~^ xb) & ({W{i[0]}} ~^ xc));
    end
  endtask

  task automatic t_named();
    logic [W-1:0] xa = rnd(), xb = rnd(), xc = rnd();
    op(xa, xb, xc, 8'h96, 16'h00FF, 1'b1, 1'b0, '0);
    chk("R2 xor3", out_data, xa ^ xb ^ xc);
    op(xa, xb, xc, 8'hE8, 16'h00FF, 1'b1, 1'b0, '0);
    chk("R2 majority", out_data, (xa & xb) | (xa & xc) | (xb & xc));
    op(xa, xb, xc, 8'hCA, 16'h00FF, 1'b1, 1'b0, '0);
    chk("R2 select", out_data, (xa & xb) | (~xa & xc));
  endtask

  task automatic t_consts();
    logic [W-1:0] xa = rnd(), xb = rnd(), xc = rnd();
    op(xa, xb, xc, 8'h00, 16'hFFFF, 1'b0, 1'b1, rnd());
    chk("R3 zero", out_data, '0);
    op(xa, xb, xc, 8'hFF, 16'hFFFF, 1'b0, 1'b1, rnd());
    chk("R3 ones", out_data, '1);
    op(xa, xb, xc, 8'h80, 16'hFFFF, 1'b1, 1'b1, '0);
    chk("R3 and3", out_data, xa & xb & xc);
    op(xa, xb, xc, 8'hFE, 16'hFFFF, 1'b1, 1'b1, '0);
    chk("R3 or3", out_data, xa | xb | xc);
  endtask

  task automatic t_wide_mask();
    logic [W-1:0] exp;
    for (int i = 0; i < 8; i++) exp[i*64 +: 64] = (i % 2 == 1) ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0;
    op(rnd(), rnd(), rnd(), 8'hFF, 16'hFFAA, 1'b1, 1'b0, '0);
    chk("R4 wide lanes, upper mask ignored", out_data, exp);
  endtask

  task automatic t_narrow_mask();
    logic [W-1:0] exp;
    for (int i = 0; i < 16; i++) exp[i*32 +: 32] = (i % 3 == 0) ? 32'hFFFF_FFFF : 32'h0;
    op(rnd(), rnd(), rnd(), 8'hFF, 16'h9249, 1'b1, 1'b1, '0);
    chk("R5 narrow lanes", out_data, exp);
  endtask

  task automatic t_zero_merge();
    logic [W-1:0] xa = rnd(), xb = rnd(), xc = rnd(), s = rnd();
    op(xa, xb, xc, 8'h96, 16'h0000, 1'b1, 1'b1, s);
    chk("R6 all lanes zeroed", out_data, '0);
    op(xa, xb, xc, 8'h96, 16'h0000, 1'b0, 1'b0, s);
    chk("R7 all lanes merged", out_data, s);
    op(xa, xb, xc, 8'h96, 16'h0F0F, 1'b0, 1'b1, s);
    chk("R7 partial merge", out_data, model(xa, xb, xc, 8'h96, 16'h0F0F, 1'b0, 1'b1, s));
  endtask

  task automatic t_random();
    for (int n = 0; n < 40; n++) begin
      logic [W-1:0] xa = rnd(), xb = rnd(), xc = rnd(), s = rnd();
      logic [7:0] t = 8'($urandom);
      logic [15:0] m = 16'($urandom);
      logic z = n[0], nr = n[1];
      op(xa, xb, xc, t, m, z, nr, s);
      chk($sformatf("R1 random #%0d", n), out_data, model(xa, xb, xc, t, m, z, nr, s));
    end
  endtask

  task automatic t_timing();
    logic [W-1:0] xa = rnd(), xb = rnd(), xc = rnd(), exp;
    exp = xa ^ xb ^ xc;
    @(negedge clk);
    a = xa; b = xb; c = xc; imm = 8'h96; msk = 16'hFFFF; zs = 1'b1; nar = 1'b0; in_valid = 1'b1;
    @(posedge clk); #1;
    chk1("R8 valid one cycle later", out_valid, 1'b1);
    chk("R8 data one cycle later", out_data, exp);
    @(negedge clk);
    in_valid = 1'b0; a = rnd(); imm = 8'hFF;
    @(posedge clk); #1;
    chk1("R8 valid drops", out_valid, 1'b0);
    chk("R8 data held", out_data, exp);
    // R9: reset wins over a pending strobe
    @(negedge clk); in_valid = 1'b1; rst = 1'b1;
    @(posedge clk); #1;
    chk1("R9 reset overrides strobe valid", out_valid, 1'b0);
    chk("R9 reset overrides strobe data", out_data, '0);
    @(negedge clk); in_valid = 1'b0; rst = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    t_reset();
    t_index_order();
    t_named();
    t_consts();
    t_wide_mask();
    t_narrow_mask();
    t_zero_merge();
    t_random();
    t_timing();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule